// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides, cycle by cycle, whether the oscillator runs and whether the CPU and the peripherals receive a clock enable. The CPU controls it through a byte-wide power-control register. The register offers three modes. Idle stops only the CPU. Power down stops everything, including the oscillator. Slow down divides the enable rate of the whole chip by 32, and it can stay active while the chip is idle. Idle and power down can only be entered through an arming sequence: the companion arming bit must be written in the write just before the mode bit. This protects against a stray single write.

Idle ends on any enabled interrupt request. Power down ends on a short low pulse on either of two wake-up pins. The pins are synchronised with two flip-flops. After a wake-up the oscillator is switched on, and the block waits a fixed start-up count with all clocks off before it returns to normal operation. The idle and power-down request bits clear themselves when their mode ends. The slow-down bit stays set until software clears it. An asynchronous hardware reset leaves any mode immediately.

The block runs on an always-on reference clock. Slow down is produced as one-cycle enable pulses, not as a derived clock. All pins are plain control and status pins. The block has no streaming data interface, so there is no valid/ready handshake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00 and osc_en, cpu_ce and per_ce are all 1.
- R2: The register layout is as follows. Bit 0 requests idle and bit 1 requests power down. Bit 4 enables slow down. Bit 5 arms idle and bit 6 arms power down. Bits 2, 3 and 7 always read 0, and writing them has no effect. rd_data always shows the current register value.
- R3: A mode bit takes effect only if its arming bit was set by the immediately preceding accepted write. Every accepted write reloads both arming bits from its own data, so any other write in between disarms them.
- R4: If one write validly requests both idle and power down, power down wins and bit 0 stays 0.
- R5: In idle, cpu_ce is 0 while osc_en stays 1 and per_ce keeps running. Register writes are accepted only in normal operation, so writes made during idle are ignored.
- R6: While idle, an irq_req sampled high returns the block to normal operation at the next clock edge. cpu_ce comes back and bit 0 clears.
- R7: In power down, osc_en, cpu_ce and per_ce are all 0, and irq_req has no effect.
- R8: A low level on wake_a_n or wake_b_n, seen through a two-flop synchroniser during power down, sets osc_en to 1. The CPU and peripheral enables then stay off for exactly STARTUP (16) cycles before normal operation resumes, and bit 1 clears at that point.
- R9: With bit 4 set, cpu_ce and per_ce are one-cycle pulses spaced exactly 32 cycles apart. With bit 4 clear, they are high every cycle outside idle and power down.
- R10: Slow down stays set through idle and its exit, and it keeps pacing per_ce during idle. Only a write of 0 to bit 4, or a reset, clears it.
- R11: Hardware reset exits idle and power down immediately and restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register value |
| irq_req | input | 1 | Any enabled interrupt request |
| wake_a_n | input | 1 | Asynchronous active-low wake-up pin A |
| wake_b_n | input | 1 | Asynchronous active-low wake-up pin B |
| osc_en | output | 1 | Oscillator enable |
| cpu_ce | output | 1 | CPU clock enable |
| per_ce | output | 1 | Peripheral clock enable |

## Verification
The core sweep writes each of the four arming patterns, then every one of the 256 byte values as the next write. Each pair is checked against a mode and readback computed arithmetically. This separates correct arming from arming taken from the wrong bit, shows that power down wins over idle, and confirms that the unused bits are masked. Directed sequences add four more checks:
- an intervening write that must disarm the mode;
- the interrupt exit from idle;
- wake-up through each pin separately, counting the start-up window cycle by cycle;
- the spacing of the slow-down pulses, both in normal operation and during idle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int REG_W     = 8;
  localparam int B_IDLE    = 0;
  localparam int B_PD      = 1;
  localparam int B_SLOW    = 4;
  localparam int B_ARM_IDL = 5;
  localparam int B_ARM_PD  = 6;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2,
    PM_WAKE  = 2'd3
  } pm_state_t;
endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pwr_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [REG_W-1:0] wr_data,
  input  logic             clr_idle,
  input  logic             clr_pd,
  output logic             go_idle,
  output logic             go_pd,
  output logic             slow_en,
  output logic [REG_W-1:0] rd_data
);
  logic idle_q, pd_q, slow_q, arm_idle_q, arm_pd_q;
  logic unused_bits;

  assign unused_bits = ^{wr_data[7], wr_data[3:2]};

  assign go_pd   = wr_ok && wr_data[B_PD] && arm_pd_q;
  assign go_idle = wr_ok && wr_data[B_IDLE] && arm_idle_q && !go_pd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q     <= 1'b0;
      pd_q       <= 1'b0;
      slow_q     <= 1'b0;
      arm_idle_q <= 1'b0;
      arm_pd_q   <= 1'b0;
    end else begin
      if (wr_ok) begin
        slow_q     <= wr_data[B_SLOW];
        arm_idle_q <= wr_data[B_ARM_IDL];
        arm_pd_q   <= wr_data[B_ARM_PD];
      end
      if (go_idle)       idle_q <= 1'b1;
      else if (clr_idle) idle_q <= 1'b0;
      if (go_pd)         pd_q <= 1'b1;
      else if (clr_pd)   pd_q <= 1'b0;
    end
  end

  assign slow_en = slow_q;

  always_comb begin
    rd_data            = '0;
    rd_data[B_IDLE]    = idle_q;
    rd_data[B_PD]      = pd_q;
    rd_data[B_SLOW]    = slow_q;
    rd_data[B_ARM_IDL] = arm_idle_q;
    rd_data[B_ARM_PD]  = arm_pd_q;
  end

  // R3
  idle_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> $past(arm_idle_q));
  // R4
  one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_q && pd_q));
endmodule

// File: rtl/pmc_slow_div.sv
module pmc_slow_div #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_en,
  input  logic hold,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!slow_en || hold)  cnt_q <= '0;
    else if (cnt_q == LAST)     cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick = !slow_en || (cnt_q == LAST);

  // R9
  slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_en && tick && !hold) |=> (!tick || !slow_en));
  // R9
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_en |-> tick);
endmodule

// File: rtl/pmc_wake.sv
module pmc_wake #(
  parameter int STARTUP = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_a_n,
  input  logic pin_b_n,
  input  logic in_wake,
  output logic wake_req,
  output logic start_done
);
  localparam int SW = (STARTUP > 1) ? $clog2(STARTUP) : 1;
  localparam logic [SW-1:0] LAST = SW'(STARTUP - 1);

  logic [1:0]    sync_a, sync_b;
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 2'b11;
      sync_b <= 2'b11;
    end else begin
      sync_a <= {sync_a[0], pin_a_n};
      sync_b <= {sync_b[0], pin_b_n};
    end
  end

  assign wake_req = !sync_a[1] || !sync_b[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!in_wake) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign start_done = in_wake && (cnt_q == LAST);

  // R8
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_wake |=> (cnt_q == '0) || in_wake);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int DIV     = 32,
  parameter int STARTUP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             irq_req,
  input  logic             wake_a_n,
  input  logic             wake_b_n,
  output logic             osc_en,
  output logic             cpu_ce,
  output logic             per_ce
);
  pm_state_t state_q, state_d;
  logic wr_ok, go_idle, go_pd, slow_en, tick, wake_req, start_done;
  logic clr_idle, clr_pd;

  assign wr_ok    = wr_en && (state_q == PM_RUN);
  assign clr_idle = (state_q == PM_IDLE) && irq_req;
  assign clr_pd   = start_done;

  pmc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_data(wr_data),
    .clr_idle(clr_idle), .clr_pd(clr_pd), .go_idle(go_idle),
    .go_pd(go_pd), .slow_en(slow_en), .rd_data(rd_data)
  );

  pmc_slow_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en),
    .hold(state_q == PM_PDOWN || state_q == PM_WAKE), .tick(tick)
  );

  pmc_wake #(.STARTUP(STARTUP)) u_wake (
    .clk(clk), .rst_n(rst_n), .pin_a_n(wake_a_n), .pin_b_n(wake_b_n),
    .in_wake(state_q == PM_WAKE), .wake_req(wake_req),
    .start_done(start_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN:   if (go_pd) state_d = PM_PDOWN;
                else if (go_idle) state_d = PM_IDLE;
      PM_IDLE:  if (irq_req) state_d = PM_RUN;
      PM_PDOWN: if (wake_req) state_d = PM_WAKE;
      PM_WAKE:  if (start_done) state_d = PM_RUN;
      default:  state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_d;
  end

  assign osc_en = (state_q != PM_PDOWN);
  assign cpu_ce = (state_q == PM_RUN) && tick;
  assign per_ce = (state_q == PM_RUN || state_q == PM_IDLE) && tick;

  // R5
  cpu_under_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> per_ce);
  // R7
  pd_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == PM_PDOWN) |-> $past(wr_en));
  // R6
  idle_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE) |-> rd_data[B_IDLE]);
  // R8
  wake_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_WAKE) |-> (osc_en && !per_ce && rd_data[B_PD]));
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_req = 1'b0;
  logic       wake_a_n = 1'b1;
  logic       wake_b_n = 1'b1;
  logic       osc_en, cpu_ce, per_ce;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_req(irq_req), .wake_a_n(wake_a_n),
    .wake_b_n(wake_b_n), .osc_en(osc_en), .cpu_ce(cpu_ce), .per_ce(per_ce)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] b);
    @(negedge clk) begin wr_en = 1'b1; wr_data = b; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic wake_via(input bit use_b, input string tag);
    int n;
    do_reset();
    do_write(8'h40);
    do_write(8'h02);
    chk({tag, " pd osc"}, osc_en, 0);
    if (use_b) wake_b_n = 1'b0; else wake_a_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wake_a_n = 1'b1; wake_b_n = 1'b1;
    n = 0;
    while (!osc_en && n < 10) begin n++; @(negedge clk); end
    chk({tag, " osc on"}, osc_en, 1);
    n = 0;
    while (!cpu_ce && n < 100) begin
      if (per_ce) n = 200;
      n++;
      @(negedge clk);
    end
    chk({tag, " startup cycles"}, n, 16);
    chk({tag, " pd bit cleared"}, rd_data, 8'h00);
  endtask

  initial begin
    int gap, pc, cc;
    logic [7:0] first;
    logic ei, ep;
    do_reset();
    // R1
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 enables", {osc_en, cpu_ce, per_ce}, 3'b111);

    // R2 R3 R4 R7: sweep of arming pattern x second write
    for (int a = 0; a < 4; a++) begin
      for (int s = 0; s < 256; s++) begin
        logic [7:0] sb;
        logic [7:0] exp_rd;
        sb = 8'(s);
        first = 8'(a << 5);
        do_reset();
        do_write(first);
        do_write(sb);
        ep = sb[1] & first[6];
        ei = sb[0] & first[5] & ~ep;
        exp_rd = (sb & 8'h70) | {6'b0, ep, ei};
        chk("R2/R3/R4 readback", rd_data, exp_rd);
        chk("R7 osc_en", osc_en, !ep);
        if (!sb[4]) begin
          chk("R5/R9 per_ce", per_ce, !ep);
          chk("R3 cpu_ce", cpu_ce, !ep && !ei);
        end
      end
    end

    // R3: intervening write disarms
    do_reset();
    do_write(8'h20);
    do_write(8'h00);
    do_write(8'h01);
    chk("R3 disarmed by intervening write", {rd_data[0], cpu_ce}, 2'b01);

    // R5 R6: idle, ignored writes, interrupt exit
    do_reset();
    do_write(8'h20);
    do_write(8'h01);
    chk("R5 idle enables", {osc_en, cpu_ce, per_ce}, 3'b101);
    do_write(8'h52);
    chk("R5 write in idle ignored", rd_data, 8'h01);
    @(negedge clk) irq_req = 1'b1;
    @(negedge clk) irq_req = 1'b0;
    chk("R6 idle exit cpu_ce", cpu_ce, 1);
    chk("R6 idle bit cleared", rd_data, 8'h00);

    // R7: irq ignored in power down
    do_reset();
    do_write(8'h40);
    do_write(8'h02);
    irq_req = 1'b1;
    repeat (3) @(negedge clk);
    irq_req = 1'b0;
    chk("R7 irq ignored in pd", {osc_en, cpu_ce, per_ce}, 3'b000);
    // R11: reset leaves power down
    do_reset();
    chk("R11 reset from pd", {rd_data, osc_en, cpu_ce, per_ce}, {8'h00, 3'b111});

    // R8
    wake_via(1'b0, "R8 pin A");
    wake_via(1'b1, "R8 pin B");

    // R9: slow down spacing
    do_reset();
    do_write(8'h10);
    gap = 0;
    while (!per_ce && gap < 40) begin gap++; @(negedge clk); end
    @(negedge clk);
    gap = 1;
    while (!per_ce && gap < 40) begin gap++; @(negedge clk); end
    chk("R9 pulse spacing", gap, 32);
    pc = 0; cc = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      pc += per_ce; cc += cpu_ce;
    end
    chk("R9 per_ce pulses in 64", pc, 2);
    chk("R9 cpu_ce pulses in 64", cc, 2);

    // R10: slow persists in idle
    do_write(8'h30);
    do_write(8'h11);
    pc = 0; cc = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      pc += per_ce; cc += cpu_ce;
    end
    chk("R10 per_ce in slow idle", pc, 2);
    chk("R10 cpu_ce in slow idle", cc, 0);
    @(negedge clk) irq_req = 1'b1;
    @(negedge clk) irq_req = 1'b0;
    chk("R10 slow kept after idle", rd_data, 8'h10);
    do_write(8'h00);
    chk("R9 full rate after clear", {cpu_ce, per_ce}, 2'b11);
    do_write(8'h10);
    do_reset();
    chk("R10 reset clears slow", {rd_data, per_ce}, {8'h00, 1'b1});

    // R11: reset leaves idle
    do_write(8'h20);
    do_write(8'h01);
    do_reset();
    chk("R11 reset from idle", {rd_data, cpu_ce}, {8'h00, 1'b1});

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule